// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt sources for a processor core, holds each one in a pending flag and applies enable masking. It picks the highest-ranked source that is active and gives the core a 16-bit vector address for it. The sources are a reset request, a non-maskable edge input, three edge inputs with selectable polarity, a level input merged with four internal timer flags, and two plain level inputs. The reset request is offered at once. Every other source is offered only while the core marks an instruction boundary.

Software reaches four byte-wide registers over a small read/write bus. The first holds the enables and the global enable. The second holds the pending flags. The third holds the edge polarities, the timer enables and a read-only copy of the saved global enable. The fourth holds the timer pending flags. When the core acknowledges a request, the block saves the global enable and then clears it. When the core signals a return-with-enable, the block restores the saved value. Software may set the global enable again inside a handler so that interrupts can nest.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `irq_req` is low while no source pin is high.
- R2: Source index i (0 reset, 1 NMI, 2..4 edge inputs e0..e2, 5 merged level/timer, 6 and 7 level inputs) ranks above every higher index. When `irq_req` is high, `irq_vector` equals 0xFFFE minus 2*i for the winning index i.
- R3: An active reset source (index 0) raises `irq_req` whatever `boundary` is. Any other source raises it only in cycles with `boundary` high.
- R4: A source with index 2..7 takes part in arbitration only when its own enable (ENABLE bit i, register address 0) and the global enable (ENABLE bit 0) are both 1. Indices 0 and 1 ignore both enables.
- R5: A rising edge on `nmi_pin` sets PENDING (address 1) bit 1. A bus write leaves that bit unchanged. Only an acknowledge of vector 0xFFFC clears it.
- R6: Edge input `ext_pin[k]` sets PENDING bit k+2. CONDITION (address 2) bit k selects the polarity: 1 for rising, 0 for falling. Writing 0 to the bit clears it and writing 1 leaves it unchanged. An acknowledge of its vector also clears it.
- R7: While `int6_pin` or `int7_pin` is high, PENDING bit 6 or 7 is set. An acknowledge does not clear these bits. Only a bus write of 0 clears them, and the clear sticks only once the pin is low.
- R8: A high `tmr_irq[t]` sets TIMER-PENDING (address 3) bit t whether or not that timer is enabled. PENDING bit 5 is set while `int5_pin` is high, or while any timer has both its pending bit and its enable (CONDITION bit 4+t) at 1. Both registers are cleared only by bus writes of 0.
- R9: Pending flags are set by their trigger condition even when the source is disabled.
- R10: A taken acknowledge (`ack` while `irq_req` is high) copies the global enable into CONDITION bit 3 and clears ENABLE bit 0. `reti` copies CONDITION bit 3 back into ENABLE bit 0, and a bus write to ENABLE may set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Reset interrupt source, active-high level |
| nmi_pin | input | 1 | Non-maskable source, rising edge |
| ext_pin | input | 3 | Edge sources e0..e2, polarity selectable |
| int5_pin | input | 1 | Level source merged with the timer flags |
| int6_pin | input | 1 | Level source, index 6 |
| int7_pin | input | 1 | Level source, index 7 |
| tmr_irq | input | 4 | Internal timer interrupt flags |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| ack | input | 1 | Core acknowledges the offered vector |
| reti | input | 1 | Return-with-enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | 16 | Vector address of the winning source |

## Verification
The arbiter is swept over all 64 pending combinations of sources 2..7. Each combination is tried under four enable masks with the global enable set, and once with the global enable cleared. The masks show whether the lowest index really wins, whether a disabled source is skipped in favour of the next one, and whether the global enable blocks every maskable source. Directed sequences then exercise each clearing rule: write-zero versus write-one on the edge flags, acknowledge against the NMI and edge flags versus the level flags, and the timer flags with their enables off and on. These sequences also cover both edge polarities and the save and restore of the global enable around an acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NSRC   = 8;
    localparam int IDXW   = $clog2(NSRC);
    localparam int NTMR   = 4;
    localparam int NEXT   = 3;
    localparam int DW     = 8;
    localparam int AW     = 2;

    localparam int SRC_RESET = 0;
    localparam int SRC_NMI   = 1;
    localparam int SRC_EXT0  = 2;
    localparam int SRC_MIX5  = 5;

    typedef enum logic [AW-1:0] {
        REG_ENABLE = 2'd0,
        REG_PEND   = 2'd1,
        REG_COND   = 2'd2,
        REG_TPEND  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } grant_t;

    function automatic logic [15:0] vec_of(input logic [15:0] top,
                                           input logic [15:0] step,
                                           input logic [IDXW-1:0] idx);
        return top - step * 16'(idx);
    endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pirq_pending.sv
module pirq_pending
    import prio_irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   nmi_q,
    input  logic [NEXT-1:0]        ext_q,
    input  logic [NEXT-1:0]        ext_pol,
    input  logic                   lvl5,
    input  logic                   lvl6,
    input  logic                   lvl7,
    input  logic [NTMR-1:0]        tmr_irq,
    input  logic [NTMR-1:0]        tmr_en,
    input  logic                   wr_pend,
    input  logic                   wr_tpend,
    input  logic [DW-1:0]          wdata,
    input  logic [NEXT:0]          hw_clr,
    output logic [NSRC-1:1]        pend,
    output logic [NTMR-1:0]        tpend
);
    logic            nmi_prev;
    logic [NEXT-1:0] ext_prev;
    logic [NEXT-1:0] ext_hit;
    logic [NSRC-1:1] set_v, wclr, hclr, pend_q;
    logic [NTMR-1:0] tpend_q, tclr;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            ext_prev <= '0;
        end else begin
            nmi_prev <= nmi_q;
            ext_prev <= ext_q;
        end
    end

    genvar k;
    generate
        for (k = 0; k < NEXT; k++) begin : g_edge
            assign ext_hit[k] = ext_pol[k] ? (ext_q[k] & ~ext_prev[k])
                                           : (~ext_q[k] & ext_prev[k]);
        end
    endgenerate

    always_comb begin
        set_v                       = '0;
        set_v[SRC_NMI]              = nmi_q & ~nmi_prev;
        set_v[SRC_EXT0 +: NEXT]     = ext_hit;
        set_v[SRC_MIX5]             = lvl5 | (|(tpend_q & tmr_en));
        set_v[6]                    = lvl6;
        set_v[7]                    = lvl7;

        wclr = '0;
        if (wr_pend) wclr[NSRC-1:SRC_EXT0] = ~wdata[NSRC-1:SRC_EXT0];

        hclr = '0;
        hclr[NEXT+1:1] = hw_clr;

        tclr = wr_tpend ? ~wdata[NTMR-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            tpend_q <= '0;
        end else begin
            pend_q  <= (pend_q & ~wclr & ~hclr) | set_v;
            tpend_q <= (tpend_q & ~tclr) | tmr_irq;
        end
    end

    assign pend  = pend_q;
    assign tpend = tpend_q;

    // R5: NMI flag survives everything except its own acknowledge
    a_r5_nmi_holds: assert property (@(posedge clk) disable iff (rst)
        pend_q[SRC_NMI] && !hw_clr[0] |=> pend_q[SRC_NMI]);

    // R6: writing a one to an edge flag keeps it
    a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
        wr_pend && wdata[SRC_EXT0] && pend_q[SRC_EXT0] && !hw_clr[1]
        |=> pend_q[SRC_EXT0]);

    // R7: level flags are not cleared by acknowledge
    a_r7_level_sticky: assert property (@(posedge clk) disable iff (rst)
        pend_q[6] && !(wr_pend && !wdata[6]) |=> pend_q[6]);

    // R8: a timer flag stays until software clears it
    a_r8_timer_sticky: assert property (@(posedge clk) disable iff (rst)
        tpend_q[0] && !(wr_tpend && !wdata[0]) |=> tpend_q[0]);
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import prio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] active,
    output grant_t          grant
);
    logic [NSRC-1:0] win_oh;

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_win
            if (i == 0) begin : g_top
                assign win_oh[i] = active[i];
            end else begin : g_rest
                assign win_oh[i] = active[i] & ~(|active[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        grant = '0;
        for (int j = NSRC - 1; j >= 0; j--) begin
            if (active[j]) begin
                grant.valid = 1'b1;
                grant.idx   = IDXW'(j);
            end
        end
    end

    // R2: single winner, it is active, nothing lower-indexed is active
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_oh));
    a_r2_winner_active: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> win_oh[grant.idx]);
    a_r2_idle_when_none: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> !grant.valid);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter logic [15:0] VEC_TOP     = 16'hFFFE,
    parameter logic [15:0] VEC_STEP    = 16'd2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reset_req,
    input  logic            nmi_pin,
    input  logic [NEXT-1:0] ext_pin,
    input  logic            int5_pin,
    input  logic            int6_pin,
    input  logic            int7_pin,
    input  logic [NTMR-1:0] tmr_irq,
    input  logic            boundary,
    input  logic            ack,
    input  logic            reti,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_req,
    output logic [15:0]     irq_vector
);
    logic [NSRC-1:0]        pin_q;
    logic [NSRC-1:1]        pend;
    logic [NTMR-1:0]        tpend;
    logic [NSRC-1:SRC_EXT0] en_q;
    logic                   gie_q, saved_q;
    logic [NEXT-1:0]        pol_q;
    logic [NTMR-1:0]        tmr_en_q;
    logic [NSRC-1:0]        active;
    logic [NEXT:0]          hw_clr;
    grant_t                 grant;
    logic                   ack_eff;
    logic                   wr_en, wr_pend, wr_cond, wr_tpend;

    pirq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({int7_pin, int6_pin, int5_pin, ext_pin, nmi_pin, reset_req}),
        .q   (pin_q)
    );

    assign wr_en    = bus_wr && (bus_addr == REG_ENABLE);
    assign wr_pend  = bus_wr && (bus_addr == REG_PEND);
    assign wr_cond  = bus_wr && (bus_addr == REG_COND);
    assign wr_tpend = bus_wr && (bus_addr == REG_TPEND);

    pirq_pending u_pend (
        .clk      (clk),
        .rst      (rst),
        .nmi_q    (pin_q[SRC_NMI]),
        .ext_q    (pin_q[SRC_EXT0 +: NEXT]),
        .ext_pol  (pol_q),
        .lvl5     (pin_q[5]),
        .lvl6     (pin_q[6]),
        .lvl7     (pin_q[7]),
        .tmr_irq  (tmr_irq),
        .tmr_en   (tmr_en_q),
        .wr_pend  (wr_pend),
        .wr_tpend (wr_tpend),
        .wdata    (bus_wdata),
        .hw_clr   (hw_clr),
        .pend     (pend),
        .tpend    (tpend)
    );

    always_comb begin
        active                   = '0;
        active[SRC_RESET]        = pin_q[SRC_RESET];
        active[SRC_NMI]          = pend[SRC_NMI];
        active[NSRC-1:SRC_EXT0]  = pend[NSRC-1:SRC_EXT0] & en_q & {(NSRC-SRC_EXT0){gie_q}};
    end

    pirq_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .grant  (grant)
    );

    assign irq_req    = grant.valid && ((grant.idx == IDXW'(SRC_RESET)) || boundary);
    assign irq_vector = irq_req ? vec_of(VEC_TOP, VEC_STEP, grant.idx) : 16'h0000;
    assign ack_eff    = ack && irq_req;

    genvar k;
    generate
        for (k = 0; k <= NEXT; k++) begin : g_hwclr
            assign hw_clr[k] = ack_eff && (grant.idx == IDXW'(k + SRC_NMI));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            gie_q    <= 1'b0;
            saved_q  <= 1'b0;
            pol_q    <= '0;
            tmr_en_q <= '0;
        end else begin
            if (wr_en) en_q <= bus_wdata[NSRC-1:SRC_EXT0];
            if (wr_cond) begin
                pol_q    <= bus_wdata[NEXT-1:0];
                tmr_en_q <= bus_wdata[DW-1:DW-NTMR];
            end
            if (ack_eff) begin
                saved_q <= gie_q;
                gie_q   <= 1'b0;
            end else if (reti) begin
                gie_q   <= saved_q;
            end else if (wr_en) begin
                gie_q   <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_ENABLE: bus_rdata = {en_q, 1'b0, gie_q};
            REG_PEND:   bus_rdata = {pend, pin_q[SRC_RESET]};
            REG_COND:   bus_rdata = {tmr_en_q, saved_q, pol_q};
            REG_TPEND:  bus_rdata = {{(DW-NTMR){1'b0}}, tpend};
            default:    bus_rdata = '0;
        endcase
    end

    // R10: acknowledge saves then clears the global enable
    a_r10_ack_saves: assert property (@(posedge clk) disable iff (rst)
        ack_eff |=> !gie_q && (saved_q == $past(gie_q)));

    // R10: return restores the saved enable
    a_r10_reti_restores: assert property (@(posedge clk) disable iff (rst)
        reti && !ack_eff |=> gie_q == $past(saved_q));

    // R3: away from a boundary only the reset vector is offered
    a_r3_off_boundary: assert property (@(posedge clk) disable iff (rst)
        irq_req && !boundary |-> irq_vector == VEC_TOP);

    // R4: with global enable off only reset and NMI vectors appear
    a_r4_masked: assert property (@(posedge clk) disable iff (rst)
        irq_req && !gie_q |-> irq_vector >= VEC_TOP - VEC_STEP);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req = 0, nmi_pin = 0, int5_pin = 0, int6_pin = 0, int7_pin = 0;
    logic [2:0]  ext_pin = '0;
    logic [3:0]  tmr_irq = '0;
    logic        boundary = 0, ack = 0, reti = 0, bus_wr = 0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_req;
    logic [15:0] irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .reset_req(reset_req), .nmi_pin(nmi_pin),
        .ext_pin(ext_pin), .int5_pin(int5_pin), .int6_pin(int6_pin),
        .int7_pin(int7_pin), .tmr_irq(tmr_irq), .boundary(boundary),
        .ack(ack), .reti(reti), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_ack();
        @(negedge clk);
        boundary = 1; ack = 1;
        @(negedge clk);
        ack = 0; boundary = 0;
    endtask

    task automatic do_reti();
        @(negedge clk);
        reti = 1;
        @(negedge clk);
        reti = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [5:0] en_pat [5];
        logic       gie_pat [5];
        en_pat[0] = 6'h3F; gie_pat[0] = 1;
        en_pat[1] = 6'h15; gie_pat[1] = 1;
        en_pat[2] = 6'h2A; gie_pat[2] = 1;
        en_pat[3] = 6'h00; gie_pat[3] = 1;
        en_pat[4] = 6'h3F; gie_pat[4] = 0;

        tick(3);
        rst = 0;
        tick(2);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk("R1 reg", {8'h0, r}, 16'h0000);
        end
        boundary = 1; #1;
        chk("R1 irq_req", {15'h0, irq_req}, 16'h0000);
        boundary = 0;

        // R2 R4 R9: sweep of pending combinations over enable patterns
        wr(2'd2, 8'h07);
        for (int p = 0; p < 5; p++) begin
            for (int m = 0; m < 64; m++) begin
                logic [5:0] msk;
                logic       exp_req;
                int         exp_idx;
                msk = 6'(m);
                wr(2'd0, {en_pat[p], 1'b0, gie_pat[p]});
                ext_pin = msk[2:0]; int5_pin = msk[3]; int6_pin = msk[4]; int7_pin = msk[5];
                tick(5);
                ext_pin = '0; int5_pin = 0; int6_pin = 0; int7_pin = 0;
                tick(5);
                rd(2'd1, r);
                chk("R9 pending set", {8'h0, r}, {8'h0, msk, 2'b00});
                exp_req = 0; exp_idx = 0;
                for (int i = 5; i >= 0; i--)
                    if (msk[i] && en_pat[p][i] && gie_pat[p]) begin
                        exp_req = 1; exp_idx = i + 2;
                    end
                @(negedge clk);
                boundary = 1; #1;
                chk("R4 irq_req", {15'h0, irq_req}, {15'h0, exp_req});
                if (exp_req) begin
                    chk("R2 vector", irq_vector, 16'hFFFE - 16'(2 * exp_idx));
                    boundary = 0; #1;
                    chk("R3 no boundary", {15'h0, irq_req}, 16'h0000);
                end
                boundary = 0;
                wr(2'd1, 8'h00);
            end
        end
        rd(2'd1, r);
        chk("R7 write zero clears", {8'h0, r}, 16'h0000);

        // R3: reset source is offered without boundary and with gie off
        wr(2'd0, 8'h00);
        reset_req = 1; tick(5); #1;
        chk("R3 reset req", {15'h0, irq_req}, 16'h0001);
        chk("R3 reset vector", irq_vector, 16'hFFFE);
        rd(2'd1, r);
        chk("R3 reset level read", {8'h0, r}, 16'h0001);
        reset_req = 0; tick(5);

        // R5: NMI
        nmi_pin = 1; tick(5); nmi_pin = 0; tick(5);
        rd(2'd1, r);
        chk("R5 nmi set", {8'h0, r}, 16'h0002);
        wr(2'd1, 8'h00);
        rd(2'd1, r);
        chk("R5 nmi read only", {8'h0, r}, 16'h0002);
        wr(2'd0, 8'h01);
        @(negedge clk); boundary = 1; #1;
        chk("R5 nmi vector", irq_vector, 16'hFFFC);
        boundary = 0;
        do_ack();
        rd(2'd1, r);
        chk("R5 nmi ack clear", {8'h0, r}, 16'h0000);
        rd(2'd0, r);
        chk("R10 ack clears gie", {8'h0, r}, 16'h0000);
        rd(2'd2, r);
        chk("R10 saved gie", {8'h0, r}, 16'h000F);
        do_reti();
        rd(2'd0, r);
        chk("R10 reti restores", {8'h0, r}, 16'h0001);

        // R6: falling polarity on e0, write rules, ack clear
        wr(2'd2, 8'h00);
        ext_pin[0] = 1; tick(5);
        rd(2'd1, r);
        chk("R6 falling ignores rise", {8'h0, r}, 16'h0000);
        ext_pin[0] = 0; tick(5);
        rd(2'd1, r);
        chk("R6 falling sets", {8'h0, r}, 16'h0004);
        wr(2'd1, 8'hFF);
        rd(2'd1, r);
        chk("R6 write one no effect", {8'h0, r}, 16'h0004);
        wr(2'd0, 8'hFD);
        @(negedge clk); boundary = 1; #1;
        chk("R6 e0 vector", irq_vector, 16'hFFFA);
        boundary = 0;
        do_ack();
        rd(2'd1, r);
        chk("R6 ack clears", {8'h0, r}, 16'h0000);
        rd(2'd2, r);
        chk("R10 saved set", {8'h0, r}, 16'h0008);
        do_reti();

        // R7: level source, not cleared by ack, not by write while high
        int6_pin = 1; tick(5);
        wr(2'd1, 8'h00);
        rd(2'd1, r);
        chk("R7 held while high", {8'h0, r}, 16'h0040);
        int6_pin = 0; tick(5);
        @(negedge clk); boundary = 1; #1;
        chk("R7 int6 vector", irq_vector, 16'hFFF2);
        boundary = 0;
        do_ack();
        rd(2'd1, r);
        chk("R7 ack keeps", {8'h0, r}, 16'h0040);
        wr(2'd1, 8'hBF);
        rd(2'd1, r);
        chk("R7 write clears", {8'h0, r}, 16'h0000);
        do_reti();

        // R8: timers
        wr(2'd2, 8'h00);
        @(negedge clk); tmr_irq = 4'b0010;
        @(negedge clk); tmr_irq = 4'b0000;
        tick(2);
        rd(2'd3, r);
        chk("R8 timer pending", {8'h0, r}, 16'h0002);
        rd(2'd1, r);
        chk("R8 disabled timer no int5", {8'h0, r}, 16'h0000);
        wr(2'd2, 8'h20);
        tick(2);
        rd(2'd1, r);
        chk("R8 enabled timer int5", {8'h0, r}, 16'h0020);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        rd(2'd3, r);
        chk("R8 timer cleared", {8'h0, r}, 16'h0000);
        rd(2'd1, r);
        chk("R8 int5 cleared", {8'h0, r}, 16'h0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule